// File: doc/BRIEF.md
# Slave-Port Grant Arbiter

This block sits in front of one slave port of a multi-layer AHB-Lite crossbar. It decides which of up to `N` master layers owns that slave. Each master raises a request line. The granted master also reports whether its next transfer continues the current burst. The slave's `HREADY` marks the transfer boundaries where the owner may change. Mode, default master, priorities and the slot limit are static configuration inputs. They are changed only while the block is in reset.

There are two ways to pick a winner. Fixed priority picks the largest priority value, and the lower index wins a tie. Round robin searches upward from the master after the one granted last. When the block is idle it can park the grant on a default master, and that master then starts with no added latency. Parking has three policies: no parking, park on the last granted master, or park on a programmed master. Any other master receives its grant one cycle after its request is seen. A programmable slot limit forces re-arbitration during long or open-ended bursts. The grant goes out both as a one-hot vector and as an encoded id for the data-path multiplexers.

Top module: `slv_arb`

## Requirements
- R1: After reset `gnt_o` is zero and `gnt_vld_o` is low. At all times `gnt_o` is one-hot or zero, `gnt_vld_o` is high exactly when `gnt_o` is nonzero, and `gnt_o[gnt_id_o]` is set when `gnt_vld_o` is high.
- R2: An arbitration point is a rising edge with `ready_i` high where any of these holds: nothing is granted, the owner's request is low, `burst_cont_i` is low, or the slot limit is reached. At edges where `ready_i` is low the grant does not change.
- R3: With `mode_i`=0 (fixed priority), the winner is the requester with the largest 4-bit field `prio_i[4*i+3:4*i]`. On a tie the lowest index wins.
- R4: In the round-robin modes (`mode_i`=1,2,3), the winner is the first requester found when searching upward with wrap, starting at the index after the last master granted by arbitration. After reset that last master is taken as `N-1`.
- R5: With `mode_i`=1 and no request at an arbitration point, the grant is released.
- R6: With `mode_i`=2 and no request at an arbitration point, the grant parks on the last master granted by arbitration (`N-1` after reset).
- R7: With `mode_i`=0 or 3 and no request at an arbitration point, the grant parks on `dflt_id_i`.
- R8: A parked master that raises its request already holds the grant in that cycle. Any other master is granted at the first arbitration point after its request is seen.
- R9: With `slot_lim_i`=L>0 and `ready_i` high, an owner whose request and `burst_cont_i` stay high keeps the grant for exactly L cycles. Arbitration then happens again, and the round-robin search moves past that owner.
- R10: With `slot_lim_i`=0 a continuing burst is never broken.
- R11: A new owner is granted whenever the current owner's request is low at an arbitration point and some other master requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 fixed, 1 RR no park, 2 RR park last, 3 RR park fixed |
| dflt_id_i | input | IDW | Programmed default master |
| prio_i | input | N*PW | Per-master priority fields |
| slot_lim_i | input | SW | Slot cycle limit, 0 = unlimited |
| req_i | input | N | Master requests |
| burst_cont_i | input | 1 | Owner's next transfer continues its burst |
| ready_i | input | 1 | Slave transfer boundary |
| gnt_o | output | N | One-hot grant |
| gnt_id_o | output | IDW | Encoded granted master |
| gnt_vld_o | output | 1 | A master holds the grant |

## Verification
Corrupted owner or last-granted state shows at the ports within one arbitration point. The wrong master appears on `gnt_o`, or a later round-robin turn is skipped or repeated. A slot counter that is off by one moves the break by one cycle, and this is visible on the first long burst. A wrong parking decision shows on the first idle boundary, either as a missing grant or as a grant on the wrong master.

// File: rtl/slv_arb_pkg.sv
`timescale 1ns/1ps
package slv_arb_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED    = 2'd0,
    MODE_RR_NONE  = 2'd1,
    MODE_RR_LAST  = 2'd2,
    MODE_RR_FIXED = 2'd3
  } arb_mode_e;
endpackage

// File: rtl/slv_arb_prio.sv
`timescale 1ns/1ps
module slv_arb_prio #(
  parameter int N   = 16,
  parameter int PW  = 4,
  parameter int IDW = 4
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            any_o,
  output logic [IDW-1:0]  id_o
);
  logic [PW-1:0] prio_a [N];
  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign prio_a[g] = prio_i[g*PW +: PW];
  end

  logic [PW-1:0] best;
  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    best  = '0;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!any_o || prio_a[i] > best)) begin
        any_o = 1'b1;
        id_o  = IDW'(i);
        best  = prio_a[i];
      end
    end
  end
endmodule

// File: rtl/slv_arb_rr.sv
`timescale 1ns/1ps
module slv_arb_rr #(
  parameter int N   = 16,
  parameter int IDW = 4
) (
  input  logic [N-1:0]   req_i,
  input  logic [IDW-1:0] last_i,
  output logic [IDW-1:0] id_o
);
  logic [IDW-1:0] pos;
  logic           found;
  always_comb begin
    id_o  = '0;
    found = 1'b0;
    pos   = '0;
    for (int k = 0; k < N; k++) begin
      pos = IDW'((int'(last_i) + 1 + k) % N);
      if (!found && req_i[pos]) begin
        found = 1'b1;
        id_o  = pos;
      end
    end
  end
endmodule

// File: rtl/slv_arb_slot.sv
`timescale 1ns/1ps
module slv_arb_slot #(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [SW-1:0] lim_i,
  output logic          hit_o
);
  logic [SW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end
  // cnt_q = cycles already held beyond the first
  assign hit_o = (lim_i != '0) && (cnt_q >= lim_i - 1'b1);
endmodule

// File: rtl/slv_arb.sv
`timescale 1ns/1ps
module slv_arb #(
  parameter int N   = 16,
  parameter int PW  = 4,
  parameter int SW  = 8,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic [IDW-1:0]  dflt_id_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [SW-1:0]   slot_lim_i,
  input  logic [N-1:0]    req_i,
  input  logic            burst_cont_i,
  input  logic            ready_i,
  output logic [N-1:0]    gnt_o,
  output logic [IDW-1:0]  gnt_id_o,
  output logic            gnt_vld_o
);
  import slv_arb_pkg::*;

  arb_mode_e      mode;
  logic [IDW-1:0] own_q, last_q;
  logic           vld_q;
  logic           slot_hit, arb_pt, any_req, park_en;
  logic [IDW-1:0] fx_id, rr_id, win_id, park_id;
  logic           fx_any;

  assign mode = arb_mode_e'(mode_i);

  slv_arb_prio #(.N(N), .PW(PW), .IDW(IDW)) u_prio (
    .req_i (req_i), .prio_i (prio_i), .any_o (fx_any), .id_o (fx_id)
  );

  slv_arb_rr #(.N(N), .IDW(IDW)) u_rr (
    .req_i (req_i), .last_i (last_q), .id_o (rr_id)
  );

  slv_arb_slot #(.SW(SW)) u_slot (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (arb_pt),
    .lim_i (slot_lim_i), .hit_o (slot_hit)
  );

  assign any_req = |req_i;
  assign arb_pt  = ready_i && (!vld_q || !req_i[own_q] || !burst_cont_i || slot_hit);
  assign win_id  = (mode == MODE_FIXED) ? fx_id : rr_id;
  assign park_en = (mode != MODE_RR_NONE);
  assign park_id = (mode == MODE_RR_LAST) ? last_q : dflt_id_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      own_q  <= '0;
      last_q <= IDW'(N - 1);
    end else if (arb_pt) begin
      if (any_req) begin
        vld_q  <= 1'b1;
        own_q  <= win_id;
        last_q <= win_id;
      end else if (park_en) begin
        vld_q  <= 1'b1;
        own_q  <= park_id;
      end else begin
        vld_q  <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign gnt_o[g] = vld_q && (own_q == IDW'(g));
  end
  assign gnt_id_o  = own_q;
  assign gnt_vld_o = vld_q;

  logic unused_fx;
  assign unused_fx = fx_any;
endmodule

// File: rtl/slv_arb_chk.sv
`timescale 1ns/1ps
module slv_arb_chk #(
  parameter int N   = 16,
  parameter int PW  = 4,
  parameter int SW  = 8,
  parameter int IDW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_i,
  input logic [SW-1:0]   slot_lim_i,
  input logic [N-1:0]    req_i,
  input logic            burst_cont_i,
  input logic            ready_i,
  input logic [N-1:0]    gnt_o,
  input logic [IDW-1:0]  gnt_id_o,
  input logic            gnt_vld_o
);
  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (gnt_vld_o == (gnt_o != '0)) && (!gnt_vld_o || gnt_o[gnt_id_o]));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(gnt_o) && $stable(gnt_id_o));

  a_r5_no_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) && ready_i && (req_i == '0) |=> !gnt_vld_o);

  a_r7_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd1) && ready_i && (req_i == '0) |=> gnt_vld_o);

  a_r11_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o && ready_i && !req_i[gnt_id_o] && (req_i != '0)
    |=> gnt_vld_o && (gnt_id_o != $past(gnt_id_o)));

  a_r10_no_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o && ready_i && req_i[gnt_id_o] && burst_cont_i && (slot_lim_i == '0)
    |=> gnt_vld_o && $stable(gnt_id_o));
endmodule

bind slv_arb slv_arb_chk #(.N(N), .PW(PW), .SW(SW), .IDW(IDW)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .mode_i (mode_i), .slot_lim_i (slot_lim_i),
  .req_i (req_i), .burst_cont_i (burst_cont_i), .ready_i (ready_i),
  .gnt_o (gnt_o), .gnt_id_o (gnt_id_o), .gnt_vld_o (gnt_vld_o)
);

// File: tb/sim_slv_arb.sv
`timescale 1ns/1ps
module sim_slv_arb;
  localparam int N = 16, PW = 4, SW = 8, IDW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = '0;
  logic [IDW-1:0]  dflt = '0;
  logic [N*PW-1:0] prio = '0;
  logic [SW-1:0]   lim = '0;
  logic [N-1:0]    req = '0;
  logic            bc = 1'b0, rdy = 1'b0;
  logic [N-1:0]    gnt;
  logic [IDW-1:0]  gid;
  logic            gvld;

  int total = 0, bad = 0;
  int m_own, m_last, m_cnt;
  bit m_vld;

  always #10 clk = ~clk;

  slv_arb #(.N(N), .PW(PW), .SW(SW)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .mode_i (mode), .dflt_id_i (dflt),
    .prio_i (prio), .slot_lim_i (lim), .req_i (req), .burst_cont_i (bc),
    .ready_i (rdy), .gnt_o (gnt), .gnt_id_o (gid), .gnt_vld_o (gvld)
  );

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int pick_fixed(input logic [N-1:0] r);
    int w = -1, bp = -1;
    for (int i = 0; i < N; i++)
      if (r[i] && int'(prio[i*PW +: PW]) > bp) begin w = i; bp = int'(prio[i*PW +: PW]); end
    return w;
  endfunction

  function automatic int pick_rr(input logic [N-1:0] r, input int last);
    for (int k = 1; k <= N; k++) if (r[(last + k) % N]) return (last + k) % N;
    return -1;
  endfunction

  // model advance for one rising edge with the inputs currently applied
  task automatic model_step();
    bit hit, ap;
    int w;
    hit = (lim != 0) && (m_cnt >= int'(lim) - 1);
    ap  = rdy && (!m_vld || !req[m_own] || !bc || hit);
    if (ap) begin
      m_cnt = 0;
      if (req != 0) begin
        w = (mode == 2'd0) ? pick_fixed(req) : pick_rr(req, m_last);
        m_own = w; m_last = w; m_vld = 1;
      end else if (mode != 2'd1) begin
        m_own = (mode == 2'd2) ? m_last : int'(dflt);
        m_vld = 1;
      end else m_vld = 0;
    end else if (m_cnt < 255) m_cnt++;
  endtask

  task automatic cyc(input logic [N-1:0] r, input bit rd, input bit b, input string tag);
    logic [N-1:0] eg;
    @(negedge clk);
    eg = m_vld ? (N'(1) << m_own) : '0;
    chk(tag, gnt == eg && gvld == m_vld && (!m_vld || int'(gid) == m_own), {15'd0, gvld, gnt}, {15'd0, m_vld, eg});
    req = r; rdy = rd; bc = b;
    model_step();
  endtask

  task automatic do_reset(input logic [1:0] md, input logic [IDW-1:0] df, input logic [SW-1:0] lm);
    @(negedge clk);
    rst_n = 1'b0; req = '0; rdy = 1'b0; bc = 1'b0;
    mode = md; dflt = df; lim = lm;
    repeat (2) @(negedge clk);
    chk("R1 reset", gnt == '0 && !gvld, {31'd0, gvld}, 32'd0);
    rst_n = 1'b1;
    m_vld = 0; m_own = 0; m_last = N - 1; m_cnt = 0;
    model_step();
  endtask

  task automatic rand_phase(input logic [1:0] md, input string tag, input int n);
    do_reset(md, IDW'($urandom_range(0, N - 1)), SW'($urandom_range(0, 5)));
    for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'($urandom_range(0, 3));
    for (int c = 0; c < n; c++) begin
      logic [N-1:0] r;
      r = ($urandom_range(0, 3) == 0) ? '0 : (N'($urandom) & N'($urandom));
      cyc(r, $urandom_range(0, 3) != 0, $urandom_range(0, 9) < 7, tag);
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));

    // R8 zero-latency parked default, one-cycle for others (R7 parking)
    do_reset(2'd3, 4'd5, 8'd0);
    cyc('0, 1, 0, "R7");
    cyc('0, 1, 0, "R7");
    cyc(16'h0020, 1, 0, "R8");
    chk("R8 default same cycle", gnt == 16'h0020, {16'd0, gnt}, 32'h20);
    cyc(16'h0004, 1, 0, "R8");
    chk("R8 other not yet", gnt[2] == 1'b0, {16'd0, gnt}, 32'h20);
    cyc(16'h0004, 1, 0, "R8");
    chk("R8 other next cycle", gnt == 16'h0004, {16'd0, gnt}, 32'h4);

    // R2 no grant change without ready
    do_reset(2'd1, 4'd0, 8'd0);
    repeat (3) cyc(16'h0008, 0, 0, "R2");
    chk("R2 hold without ready", !gvld, {31'd0, gvld}, 32'd0);

    // R9 slot break, R11 keep within slot
    do_reset(2'd1, 4'd0, 8'd3);
    repeat (4) cyc(16'h000A, 1, 1, "R9");
    chk("R9 owner before limit", gid == 4'd1 && gvld, {28'd0, gid}, 32'd1);
    cyc(16'h000A, 1, 1, "R9");
    chk("R9 break after limit", gid == 4'd3, {28'd0, gid}, 32'd3);

    // R10 unlimited burst
    do_reset(2'd1, 4'd0, 8'd0);
    repeat (20) cyc(16'h000A, 1, 1, "R10");
    chk("R10 no break", gid == 4'd1 && gvld, {28'd0, gid}, 32'd1);

    // R3 tie goes to lower index
    do_reset(2'd0, 4'd0, 8'd0);
    prio = '0;
    prio[9*PW +: PW] = 4'd12; prio[4*PW +: PW] = 4'd12; prio[11*PW +: PW] = 4'd3;
    repeat (3) cyc(16'h0A10, 1, 0, "R3");
    chk("R3 tie lower index", gid == 4'd4, {28'd0, gid}, 32'd4);

    // R4 rotation order
    do_reset(2'd1, 4'd0, 8'd0);
    repeat (4) cyc(16'h00F0, 1, 0, "R4");
    chk("R4 rotation", gid == 4'd6, {28'd0, gid}, 32'd6);
    cyc(16'h00F0, 1, 0, "R4");
    cyc(16'h00F0, 1, 0, "R4");
    chk("R4 wrap", gid == 4'd4, {28'd0, gid}, 32'd4);

    // R6 park on last
    do_reset(2'd2, 4'd0, 8'd0);
    cyc(16'h0040, 1, 0, "R6");
    cyc('0, 1, 0, "R6");
    cyc('0, 1, 0, "R6");
    chk("R6 park last", gid == 4'd6 && gvld, {28'd0, gid}, 32'd6);

    // R5 release when idle
    do_reset(2'd1, 4'd0, 8'd0);
    cyc(16'h0100, 1, 0, "R5");
    cyc('0, 1, 0, "R5");
    cyc('0, 1, 0, "R5");
    chk("R5 released", !gvld && gnt == '0, {31'd0, gvld}, 32'd0);

    // R11 handover when owner drops
    do_reset(2'd1, 4'd0, 8'd0);
    cyc(16'h0001, 1, 1, "R11");
    cyc(16'h0800, 1, 1, "R11");
    cyc(16'h0800, 1, 1, "R11");
    chk("R11 handover", gid == 4'd11, {28'd0, gid}, 32'd11);

    // random mixes with model comparison (R1, R2, R9 throughout)
    rand_phase(2'd0, "R3", 1500);
    rand_phase(2'd1, "R5", 1500);
    rand_phase(2'd2, "R6", 1500);
    rand_phase(2'd3, "R7", 1500);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule